// File: doc/BRIEF.md
# SPI Master with Per-Word Command FIFO

This block is an SPI bus master whose transmit queue carries a small command next to each data payload. A host writes 23-bit words into a four-entry transmit FIFO. Each word names the chip selects to drive, a flag that keeps those selects asserted after the frame, and up to 16 payload bits. The engine takes one word at a time and shifts it out on SCK and MOSI. While it does so, it samples MISO, and each frame's result goes into a four-entry receive FIFO.

Two internal registers are written through a small write port. The control register holds enable, halt, two self-clearing flush bits and one idle-level bit for each chip select. The attribute register holds the frame size, the clock polarity, the clock phase, the bit order and the SCK divider. Attributes are latched at the start of each frame. Chained frames can run back to back under one select, because the hold decision travels with each word and the host does not have to time it.

Top module: `spi_cmd_master`

## Requirements
- R1: The transmit FIFO holds 4 words and `tx_count` reports its fill level. A push while it holds 4 words is ignored.
- R2: A transmit word is laid out as data in bits [15:0], a chip-select mask in bits [21:16] and the hold flag in bit 22. During a frame, every select line whose mask bit is 1 is driven to the inverse of its idle level.
- R3: When a frame's hold flag is 1, its selects stay asserted after the frame, including while the FIFO is empty, until a frame with the flag at 0 completes. When the flag is 0, the selects return to idle after that frame.
- R4: The frame length is the attribute size field (bits [3:0]) plus one bit. A value of 7 gives 8 bits, 15 gives 16 bits and 3 gives 4 bits.
- R5: Attribute bit 6 selects LSB-first order for both MOSI and MISO. When it is 0, the most significant bit of the frame goes first.
- R6: Attribute bit 4 sets the SCK idle level. With attribute bit 5 at 0, data is sampled on the leading SCK edge of each bit; with bit 5 at 1, it is sampled on the trailing edge.
- R7: Control bits [9:4] give the idle level of selects 0 to 5. After reset, all six are 1.
- R8: Every completed frame pushes one right-justified word into the receive FIFO. `rx_data` shows the oldest entry, `rx_pop` removes it, and `rx_count` reports the fill level.
- R9: A frame that completes while the receive FIFO holds 4 entries is dropped, and `st_rx_ovf` becomes 1. The flag stays 1 until the receive FIFO is flushed.
- R10: Control bit 0 enables the block and bit 1 halts it. `st_running` is 1 when the block is enabled and not halted. A new frame starts only while `st_running` is 1 and the transmit FIFO is not empty, so a halt takes effect at a frame boundary.
- R11: Writing 1 to control bit 2 empties the transmit FIFO, and writing 1 to bit 3 empties the receive FIFO. Neither bit is stored.
- R12: Each SCK half period inside a frame lasts divider+1 clock cycles, where the divider is attribute bits [15:8].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects control, 1 selects attributes |
| reg_wdata | input | 16 | Register write data |
| tx_push | input | 1 | Push `tx_word` into the transmit FIFO |
| tx_word | input | 23 | Hold flag, chip-select mask and data |
| tx_count | output | 3 | Transmit FIFO fill level |
| rx_pop | input | 1 | Remove the oldest receive entry |
| rx_data | output | 16 | Oldest receive entry |
| rx_count | output | 3 | Receive FIFO fill level |
| st_running | output | 1 | Enabled and not halted |
| st_rx_ovf | output | 1 | Sticky receive overflow |
| sck | output | 1 | SPI clock |
| mosi | output | 1 | Serial data out |
| cs_o | output | 6 | Chip-select lines |
| miso | input | 1 | Serial data in |

## Verification
A bench slave model decodes the bus and is run over a table of attribute sets that covers all four clock modes, both bit orders, 4-, 8- and 16-bit frames and several dividers. Asymmetric payloads and MISO patterns separate bit reversal from shift direction and from edge choice. The bench counts select releases, which separates chained words from isolated ones and from a hold left with an empty FIFO. Directed runs cover halting with a full queue, flushing and receive overflow, where the oldest entry must survive.

// File: rtl/scm_pkg.sv
package scm_pkg;
  localparam int DATA_W = 16;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_LEAD  = 3'd1,
    ST_SHIFT = 3'd2,
    ST_LAG   = 3'd3,
    ST_HOLD  = 3'd4
  } eng_state_t;
endpackage

// File: rtl/scm_fifo.sv
module scm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         push,
  input  logic [W-1:0]                 din,
  input  logic                         pop,
  output logic [W-1:0]                 dout,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_n, rp_n;
  logic [CW-1:0] cnt_n;
  logic          do_push, do_pop;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign do_push = push & ~full;
  assign do_pop  = pop & ~empty;
  assign dout    = mem[rp_q];

  always_comb begin
    wp_n  = wp_q;
    rp_n  = rp_q;
    cnt_n = count;
    if (do_push) wp_n = (wp_q == AW'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_n = (rp_q == AW'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop) cnt_n = count + 1'b1;
    if (do_pop && !do_push) cnt_n = count - 1'b1;
    if (flush) begin
      wp_n  = '0;
      rp_n  = '0;
      cnt_n = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      count <= '0;
    end else begin
      wp_q  <= wp_n;
      rp_q  <= rp_n;
      count <= cnt_n;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push && !flush) mem[wp_q] <= din;
  end
endmodule

// File: rtl/scm_timer.sv
module scm_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         done
);
  logic [W-1:0] cnt_q, cnt_n;

  assign done = (cnt_q == '0);

  always_comb begin
    cnt_n = cnt_q;
    if (load)          cnt_n = val;
    else if (!done)    cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end
endmodule

// File: rtl/spi_cmd_master.sv
module spi_cmd_master #(
  parameter int NCS      = 6,
  parameter int DEPTH    = 4,
  parameter int DIV_W    = 8,
  parameter int DLY_W    = 4,
  parameter int LEAD_CYC = 2,
  parameter int LAG_CYC  = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_we,
  input  logic                       reg_sel,
  input  logic [15:0]                reg_wdata,
  input  logic                       tx_push,
  input  logic [NCS+16:0]            tx_word,
  output logic [$clog2(DEPTH+1)-1:0] tx_count,
  input  logic                       rx_pop,
  output logic [15:0]                rx_data,
  output logic [$clog2(DEPTH+1)-1:0] rx_count,
  output logic                       st_running,
  output logic                       st_rx_ovf,
  output logic                       sck,
  output logic                       mosi,
  output logic [NCS-1:0]             cs_o,
  input  logic                       miso
);
  import scm_pkg::*;

  localparam int WORD_W  = NCS + 17;
  localparam int CS_LSB  = DATA_W;
  localparam int HLD_BIT = DATA_W + NCS;

  // control and attribute registers
  logic            ctl_en, ctl_halt;
  logic [NCS-1:0]  ctl_idle;
  logic [3:0]      at_fsz;
  logic            at_cpol, at_cpha, at_lsb;
  logic [DIV_W-1:0] at_div;
  logic            ctl_wr, at_wr, flush_tx, flush_rx;

  assign ctl_wr   = reg_we & ~reg_sel;
  assign at_wr    = reg_we &  reg_sel;
  assign flush_tx = ctl_wr & reg_wdata[2];
  assign flush_rx = ctl_wr & reg_wdata[3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_en   <= 1'b0;
      ctl_halt <= 1'b0;
      ctl_idle <= '1;
    end else if (ctl_wr) begin
      ctl_en   <= reg_wdata[0];
      ctl_halt <= reg_wdata[1];
      ctl_idle <= reg_wdata[4 +: NCS];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      at_fsz  <= 4'd7;
      at_cpol <= 1'b0;
      at_cpha <= 1'b0;
      at_lsb  <= 1'b0;
      at_div  <= '0;
    end else if (at_wr) begin
      at_fsz  <= reg_wdata[3:0];
      at_cpol <= reg_wdata[4];
      at_cpha <= reg_wdata[5];
      at_lsb  <= reg_wdata[6];
      at_div  <= reg_wdata[8 +: DIV_W];
    end
  end

  assign st_running = ctl_en & ~ctl_halt;

  // FIFOs
  logic [WORD_W-1:0] tx_head;
  logic              tx_full, tx_empty, tx_pop;
  logic              rx_push, rx_full, rx_empty;
  logic [15:0]       rx_fin;

  scm_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .flush(flush_tx), .push(tx_push), .din(tx_word),
    .pop(tx_pop), .dout(tx_head), .count(tx_count), .full(tx_full), .empty(tx_empty)
  );

  scm_fifo #(.W(DATA_W), .DEPTH(DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .flush(flush_rx), .push(rx_push), .din(rx_fin),
    .pop(rx_pop), .dout(rx_data), .count(rx_count), .full(rx_full), .empty(rx_empty)
  );

  // timers: SCK divider and select delays
  logic             div_load, div_done, dly_load, dly_done;
  logic [DIV_W-1:0] div_val;
  logic [DLY_W-1:0] dly_val;

  scm_timer #(.W(DIV_W)) u_div (
    .clk(clk), .rst_n(rst_n), .load(div_load), .val(div_val), .done(div_done)
  );
  scm_timer #(.W(DLY_W)) u_dly (
    .clk(clk), .rst_n(rst_n), .load(dly_load), .val(dly_val), .done(dly_done)
  );

  // frame engine
  eng_state_t       st_q, st_n;
  logic [NCS-1:0]   csa_q, csa_n;
  logic             sck_q, sck_n;
  logic [15:0]      tsh_q, tsh_n, rsh_q, rsh_n;
  logic [4:0]       edg_q, edg_n, edg_last;
  logic             hold_q, hold_n, cpha_q, cpha_n, lsb_q, lsb_n;
  logic [3:0]       fsz_q, fsz_n;
  logic [DIV_W-1:0] dv_q, dv_n;
  logic             go, start, samp, shift_ok;

  assign go       = st_running & ~tx_empty;
  assign edg_last = {fsz_q, 1'b1};
  assign samp     = (edg_q[0] == cpha_q);
  assign shift_ok = ~samp && (edg_q != 5'd0) && (edg_q != edg_last);
  assign start    = go && ((st_q == ST_IDLE) || (st_q == ST_HOLD) ||
                           ((st_q == ST_LAG) && dly_done && hold_q));

  always_comb begin
    st_n     = st_q;
    csa_n    = csa_q;
    sck_n    = sck_q;
    tsh_n    = tsh_q;
    rsh_n    = rsh_q;
    edg_n    = edg_q;
    hold_n   = hold_q;
    cpha_n   = cpha_q;
    lsb_n    = lsb_q;
    fsz_n    = fsz_q;
    dv_n     = dv_q;
    div_load = 1'b0;
    div_val  = dv_q;
    dly_load = 1'b0;
    dly_val  = DLY_W'(LEAD_CYC);
    tx_pop   = 1'b0;
    rx_push  = 1'b0;
    unique case (st_q)
      ST_IDLE: sck_n = at_cpol;
      ST_LEAD: begin
        if (dly_done) begin
          st_n     = ST_SHIFT;
          edg_n    = '0;
          div_load = 1'b1;
        end
      end
      ST_SHIFT: begin
        if (div_done) begin
          sck_n    = ~sck_q;
          edg_n    = edg_q + 1'b1;
          div_load = 1'b1;
          if (samp)
            rsh_n = lsb_q ? {miso, rsh_q[15:1]} : {rsh_q[14:0], miso};
          if (shift_ok)
            tsh_n = lsb_q ? (tsh_q >> 1) : (tsh_q << 1);
          if (edg_q == edg_last) begin
            st_n     = ST_LAG;
            rx_push  = 1'b1;
            dly_load = 1'b1;
            dly_val  = DLY_W'(LAG_CYC);
          end
        end
      end
      ST_LAG: begin
        if (dly_done) begin
          if (hold_q) st_n = ST_HOLD;
          else begin
            st_n  = ST_IDLE;
            csa_n = '0;
          end
        end
      end
      ST_HOLD: ;
      default: st_n = ST_IDLE;
    endcase
    if (start) begin
      st_n     = ST_LEAD;
      tx_pop   = 1'b1;
      csa_n    = tx_head[CS_LSB +: NCS];
      hold_n   = tx_head[HLD_BIT];
      tsh_n    = tx_head[DATA_W-1:0];
      rsh_n    = '0;
      fsz_n    = at_fsz;
      cpha_n   = at_cpha;
      lsb_n    = at_lsb;
      dv_n     = at_div;
      sck_n    = at_cpol;
      dly_load = 1'b1;
      dly_val  = DLY_W'(LEAD_CYC);
    end
  end

  // right-justify the captured word (MSB-first fills from bit 0 already)
  assign rx_fin = lsb_q ? (rsh_n >> (4'd15 - fsz_q)) : rsh_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      csa_q  <= '0;
      sck_q  <= 1'b0;
      tsh_q  <= '0;
      rsh_q  <= '0;
      edg_q  <= '0;
      hold_q <= 1'b0;
      cpha_q <= 1'b0;
      lsb_q  <= 1'b0;
      fsz_q  <= 4'd7;
      dv_q   <= '0;
    end else begin
      st_q   <= st_n;
      csa_q  <= csa_n;
      sck_q  <= sck_n;
      tsh_q  <= tsh_n;
      rsh_q  <= rsh_n;
      edg_q  <= edg_n;
      hold_q <= hold_n;
      cpha_q <= cpha_n;
      lsb_q  <= lsb_n;
      fsz_q  <= fsz_n;
      dv_q   <= dv_n;
    end
  end

  // sticky overflow
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 st_rx_ovf <= 1'b0;
    else if (flush_rx)          st_rx_ovf <= 1'b0;
    else if (rx_push && rx_full) st_rx_ovf <= 1'b1;
  end

  assign sck  = sck_q;
  assign mosi = (st_q == ST_IDLE) ? 1'b0 : (lsb_q ? tsh_q[0] : tsh_q[fsz_q]);
  assign cs_o = ctl_idle ^ csa_q;
endmodule

// File: rtl/scm_checks.sv
module scm_checks #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [$clog2(DEPTH+1)-1:0] tx_count,
  input logic [$clog2(DEPTH+1)-1:0] rx_count,
  input logic                       rx_push,
  input logic                       rx_full,
  input logic                       ovf,
  input logic                       flush_rx,
  input logic                       flush_tx,
  input logic                       run,
  input scm_pkg::eng_state_t        st
);
  import scm_pkg::*;

  p_txcnt_r1: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= ($clog2(DEPTH+1))'(DEPTH));

  p_rxcnt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rx_count <= ($clog2(DEPTH+1))'(DEPTH));

  p_ovf_set_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_push && rx_full && !flush_rx) |=> ovf);

  p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !flush_rx) |=> ovf);

  p_halt_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && st == ST_IDLE) |=> (st == ST_IDLE));

  p_flush_tx_r11: assert property (@(posedge clk) disable iff (!rst_n)
    flush_tx |=> (tx_count == '0));
endmodule

bind spi_cmd_master scm_checks #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_count(tx_count), .rx_count(rx_count),
  .rx_push(rx_push), .rx_full(rx_full), .ovf(st_rx_ovf), .flush_rx(flush_rx),
  .flush_tx(flush_tx), .run(st_running), .st(st_q)
);

// File: tb/test_spi_cmd_master.sv
`timescale 1ns/1ps
module test_spi_cmd_master;
  logic        clk, rst_n;
  logic        reg_we, reg_sel;
  logic [15:0] reg_wdata;
  logic        tx_push;
  logic [22:0] tx_word;
  logic [2:0]  tx_count, rx_count;
  logic        rx_pop;
  logic [15:0] rx_data;
  logic        st_running, st_rx_ovf, sck, mosi, miso;
  logic [5:0]  cs_o;

  spi_cmd_master i_spi_cmd_master (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .tx_push(tx_push), .tx_word(tx_word), .tx_count(tx_count), .rx_pop(rx_pop),
    .rx_data(rx_data), .rx_count(rx_count), .st_running(st_running), .st_rx_ovf(st_rx_ovf),
    .sck(sck), .mosi(mosi), .cs_o(cs_o), .miso(miso)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int nchk = 0, nerr = 0, cyc = 0;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      nerr++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // ---- bench slave model ----
  logic [5:0]  idle_b = 6'h3F;
  logic        cpol_b = 0, cpha_b = 0, mute = 0, act = 0;
  int          n_b = 8, idx = 0, ncap = 0, rel_cnt = 0;
  logic [15:0] pat_b = 0, cap = 0;
  logic [5:0]  cs_snap = 0, cs_prev = 6'h3F;
  logic        sck_prev = 0;
  time         last_t = 0, dt = 0;

  function automatic logic wbit(input int k);
    return (k < n_b) ? pat_b[n_b-1-k] : 1'b0;
  endfunction

  function automatic logic [15:0] rev(input logic [15:0] x, input int n);
    logic [15:0] r = '0;
    for (int i = 0; i < n; i++) r[n-1-i] = x[i];
    return r;
  endfunction

  initial miso = 1'b0;
  always @(cs_o, sck) begin
    if (!mute) begin
      if (cs_o !== cs_prev) begin
        if (cs_o != idle_b && !act) begin
          act = 1; cs_snap = cs_o; cap = '0; ncap = 0;
          if (!cpha_b) begin miso = wbit(0); idx = 1; end
          else idx = 0;
        end else if (cs_o == idle_b && act) begin
          act = 0; rel_cnt++;
        end
      end
      if (sck !== sck_prev && act) begin
        dt = $time - last_t; last_t = $time;
        if ((sck != cpol_b) ^ cpha_b) begin
          cap = {cap[14:0], mosi}; ncap++;
        end else begin
          miso = wbit(idx); idx++;
        end
      end
    end
    cs_prev = cs_o; sck_prev = sck;
  end

  // ---- driver tasks ----
  task automatic wreg(input logic sel, input logic [15:0] d);
    @(negedge clk); reg_we = 1; reg_sel = sel; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  function automatic logic [15:0] ctl(input logic en, input logic hl,
                                      input logic ftx, input logic frx);
    return {6'b0, idle_b, frx, ftx, hl, en};
  endfunction

  task automatic push(input logic hold, input logic [5:0] cs, input logic [15:0] d);
    @(negedge clk); tx_push = 1; tx_word = {hold, cs, d};
    @(negedge clk); tx_push = 0;
  endtask

  task automatic pop();
    @(negedge clk); rx_pop = 1;
    @(negedge clk); rx_pop = 0;
  endtask

  task automatic wait_rx(input int k);
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (rx_count >= 3'(k)) break;
    end
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  // ---- vector table ----
  typedef struct packed {
    logic [3:0]  fsz;
    logic        cpol, cpha, lsb;
    logic [7:0]  div;
    logic [5:0]  cs;
    logic [15:0] data, pat;
  } vec_t;

  localparam vec_t VT [7] = '{
    '{4'd7,  1'b0, 1'b0, 1'b0, 8'd1, 6'h01, 16'h00A5, 16'h003C},
    '{4'd7,  1'b1, 1'b0, 1'b0, 8'd0, 6'h02, 16'h0081, 16'h00C6},
    '{4'd15, 1'b0, 1'b1, 1'b0, 8'd2, 6'h04, 16'hBEEF, 16'h1234},
    '{4'd15, 1'b1, 1'b1, 1'b1, 8'd0, 6'h08, 16'h1357, 16'h8003},
    '{4'd7,  1'b0, 1'b0, 1'b1, 8'd3, 6'h10, 16'h0001, 16'h0080},
    '{4'd3,  1'b0, 1'b1, 1'b0, 8'd1, 6'h20, 16'h000B, 16'h000A},
    '{4'd7,  1'b1, 1'b1, 1'b0, 8'd5, 6'h03, 16'h006D, 16'h00B1}
  };

  initial begin
    int r0;
    rst_n = 0; reg_we = 0; reg_sel = 0; reg_wdata = '0;
    tx_push = 0; tx_word = '0; rx_pop = 0;
    idle(3);
    rst_n = 1;
    idle(2);
    chk("R7 reset select levels", cs_o, 6'h3F);
    chk("R6 reset sck", sck, 0);
    chk("R1 reset tx_count", tx_count, 0);
    chk("R8 reset rx_count", rx_count, 0);
    chk("R10 reset running", st_running, 0);
    chk("R9 reset ovf", st_rx_ovf, 0);

    wreg(0, ctl(1, 0, 0, 0));
    chk("R10 running after enable", st_running, 1);

    foreach (VT[v]) begin
      vec_t e;
      logic [15:0] ecap, erx;
      e = VT[v];
      n_b = int'(e.fsz) + 1; cpol_b = e.cpol; cpha_b = e.cpha; pat_b = e.pat;
      wreg(1, {e.div, 1'b0, e.lsb, e.cpha, e.cpol, e.fsz});
      push(0, e.cs, e.data);
      wait_rx(1);
      idle(12);
      ecap = e.lsb ? rev(e.data, n_b) : (e.data & 16'((32'd1 << n_b) - 1));
      erx  = e.lsb ? rev(e.pat, n_b) : e.pat;
      chk($sformatf("R2 v%0d asserted selects", v), cs_snap, idle_b ^ e.cs);
      chk($sformatf("R4 v%0d bits per frame", v), ncap, n_b);
      chk($sformatf("R5 R6 v%0d MOSI word", v), cap, ecap);
      chk($sformatf("R5 R8 v%0d received word", v), rx_data, erx);
      chk($sformatf("R8 v%0d rx_count", v), rx_count, 1);
      chk($sformatf("R12 v%0d half period", v), 32'(dt), 32'((e.div + 1) * 10));
      chk($sformatf("R6 v%0d sck idle level", v), sck, e.cpol);
      chk($sformatf("R3 v%0d released", v), cs_o, idle_b);
      pop();
      chk($sformatf("R8 v%0d after pop", v), rx_count, 0);
    end

    // chaining
    wreg(1, 16'h0007); cpol_b = 0; cpha_b = 0; n_b = 8; pat_b = 16'h0055;
    r0 = rel_cnt;
    push(1, 6'h01, 16'h0011);
    push(0, 6'h01, 16'h0022);
    wait_rx(2); idle(12);
    chk("R3 chained frames one release", rel_cnt - r0, 1);
    chk("R8 chained frames two entries", rx_count, 2);
    pop(); pop();
    r0 = rel_cnt;
    push(0, 6'h01, 16'h0033);
    push(0, 6'h01, 16'h0044);
    wait_rx(2); idle(12);
    chk("R3 unchained frames two releases", rel_cnt - r0, 2);
    pop(); pop();
    push(1, 6'h02, 16'h0066);
    wait_rx(1); idle(40);
    chk("R3 hold with empty FIFO", cs_o, idle_b ^ 6'h02);
    push(0, 6'h02, 16'h0077);
    wait_rx(2); idle(12);
    chk("R3 release after closing word", cs_o, idle_b);
    pop(); pop();

    // halt, full FIFO, flush
    wreg(0, ctl(1, 1, 0, 0));
    chk("R10 running cleared by halt", st_running, 0);
    for (int i = 0; i < 5; i++) push(0, 6'h01, 16'(i));
    idle(40);
    chk("R1 fifo saturates at 4", tx_count, 4);
    chk("R10 no frame while halted", rx_count, 0);
    wreg(0, ctl(1, 1, 1, 0));
    chk("R11 tx flush empties", tx_count, 0);
    wreg(0, ctl(1, 0, 0, 0));
    idle(100);
    chk("R11 flushed words not sent", rx_count, 0);

    // overflow
    pat_b = 16'h0096;
    for (int i = 0; i < 4; i++) push(0, 6'h01, 16'(8'h40 + i));
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (tx_count < 4) break;
    end
    push(0, 6'h01, 16'h00FF);
    wait_rx(4); idle(300);
    chk("R9 rx_count capped", rx_count, 4);
    chk("R9 overflow flagged", st_rx_ovf, 1);
    chk("R9 oldest entry kept", rx_data, 16'h0096);
    pop(); idle(5);
    chk("R9 overflow sticky after pop", st_rx_ovf, 1);
    wreg(0, ctl(1, 0, 0, 1));
    chk("R11 rx flush empties", rx_count, 0);
    chk("R9 overflow cleared by flush", st_rx_ovf, 0);

    // idle polarity
    mute = 1;
    idle_b = 6'h3E;
    wreg(0, ctl(1, 0, 0, 0));
    idle(1);
    act = 0; mute = 0;
    chk("R7 select 0 idles low", cs_o, 6'h3E);
    pat_b = 16'h0001;
    push(0, 6'h01, 16'h00C3);
    wait_rx(1); idle(12);
    chk("R2 R7 active-high select asserted", cs_snap, 6'h3F);
    chk("R7 select 0 back low", cs_o, 6'h3E);
    pop();

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule